// File: doc/BRIEF.md
# GPIO Interrupt Trigger and Status Unit

This unit watches the input level of every GPIO pad and turns pad activity into latched interrupt status. Each pad has a three-bit trigger setting: a level flag, a positive flag and a negative flag. Together these select rising-edge, falling-edge, either-edge, active-high or active-low detection. Clearing all three bits masks the pad. A pad with its direct-interrupt flag set is left out entirely, because that pad's interrupt is routed elsewhere.

Detected events set bits in 32-bit status words, one word per group of 32 pads. The words are placed from byte offset 0x800 on a simple register port. Software reads a word to see which pads fired and writes ones to clear them. One registered output ORs every status bit together into the unit's interrupt request.

Top module: `gpio_irq_unit`

## Requirements
- R1: With level=0, pos=1, neg=0, a low-to-high pad transition sets the pad's status bit, and a high-to-low transition sets nothing.
- R2: With level=0, pos=0, neg=1, a high-to-low transition sets the status bit, and a low-to-high transition sets nothing.
- R3: With level=0, pos=1, neg=1, both transitions set the status bit.
- R4: With level=1, pos=1, the status bit is set on every cycle that the synchronized pad is high, so a clear written while the pad is still high does not stick.
- R5: With level=1, neg=1, the status bit is set on every cycle that the synchronized pad is low.
- R6: A pad whose three trigger bits are all zero never sets its status bit, whatever its input does.
- R7: The status of pad n is bit n mod 32 of the word at byte address 0x800 + 4*(n/32). Reads of any other address return zero.
- R8: A write to a status word clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears the whole word.
- R9: If a new event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R10: A pad with its direct-interrupt flag set never sets its status bit.
- R11: After reset, every status bit is 0 and irq is 0. irq equals the OR of all status bits delayed by one clock.
- R12: A pad change sampled at rising edge k is visible in status after edge k+2, and on irq after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | NUM_PADS | Raw pad input levels |
| trig_level | input | NUM_PADS | Per-pad level flag: 1 selects level detection, 0 selects edge detection |
| trig_pos | input | NUM_PADS | Per-pad positive flag (rising edge or high level) |
| trig_neg | input | NUM_PADS | Per-pad negative flag (falling edge or low level) |
| direct_en | input | NUM_PADS | Per-pad flag that excludes the pad from this unit |
| bus_addr | input | ADDR_W | Byte address for status read and write |
| bus_we | input | 1 | Write strobe; the write is applied at the rising edge |
| bus_wdata | input | 32 | Write data; a 1 clears the matching status bit |
| bus_rdata | output | 32 | Status word at bus_addr, or zero when no word is there |
| irq | output | 1 | Registered OR of all status bits |

## Verification
A status bit that is stuck, lost or set by mistake shows up in the status word two edges after the pad change that should or should not have caused it. It shows up on irq one edge after that. The bench reads the words at those exact cycles, so a one-cycle slip in the synchronizer or the edge register is caught. A wrong clear, or a lost race between a clear and an event, leaves the word wrong right after the write. A wrong word or bit mapping puts the bit in another word or position, or lets it appear at an address that should read zero.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int WORD_W = 32;

    typedef struct packed {
        logic level;
        logic pos;
        logic neg;
    } trig_cfg_t;

    // Number of 32-bit status words needed for a pad count.
    function automatic int word_count(input int pads);
        return (pads + WORD_W - 1) / WORD_W;
    endfunction

    // Event for one pad, given its trigger setting, current and previous level.
    function automatic logic pad_event(input trig_cfg_t cfg, input logic cur, input logic prv);
        logic ev;
        if (cfg.level)
            ev = (cfg.pos & cur) | (cfg.neg & ~cur);
        else
            ev = (cfg.pos & cur & ~prv) | (cfg.neg & ~cur & prv);
        return ev;
    endfunction

endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
    parameter int NUM_PADS = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PADS-1:0] raw,
    output logic [NUM_PADS-1:0] cur,
    output logic [NUM_PADS-1:0] prv
);
    logic [NUM_PADS-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            cur  <= '0;
            prv  <= '0;
        end else begin
            meta <= raw;
            cur  <= meta;
            prv  <= cur;
        end
    end
endmodule

// File: rtl/trig_detect.sv
module trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PADS = 40
) (
    input  logic [NUM_PADS-1:0] cur,
    input  logic [NUM_PADS-1:0] prv,
    input  logic [NUM_PADS-1:0] cfg_level,
    input  logic [NUM_PADS-1:0] cfg_pos,
    input  logic [NUM_PADS-1:0] cfg_neg,
    input  logic [NUM_PADS-1:0] excluded,
    output logic [NUM_PADS-1:0] evt
);
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        trig_cfg_t cfg;
        assign cfg    = '{level: cfg_level[p], pos: cfg_pos[p], neg: cfg_neg[p]};
        assign evt[p] = ~excluded[p] & pad_event(cfg, cur[p], prv[p]);
    end
endmodule

// File: rtl/stat_bank.sv
module stat_bank #(
    parameter int NUM_PADS = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PADS-1:0] evt,
    input  logic [NUM_PADS-1:0] clr,
    output logic [NUM_PADS-1:0] stat
);
    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & ~clr) | evt;
    end

    // R9: an event in the same cycle as a clear leaves the bit set
    a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((stat & $past(evt)) == $past(evt)));

    // R8: a cleared bit with no competing event reads zero
    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((stat & $past(clr & ~evt)) == '0));

    // R8: bits that are neither written with 1 nor hit by an event keep their value
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (((stat ^ $past(stat)) & $past(~clr & ~evt)) == '0));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int          NUM_PADS  = 40,
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] STAT_BASE = 12'h800
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PADS-1:0] pad_in,
    input  logic [NUM_PADS-1:0] trig_level,
    input  logic [NUM_PADS-1:0] trig_pos,
    input  logic [NUM_PADS-1:0] trig_neg,
    input  logic [NUM_PADS-1:0] direct_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                irq
);
    localparam int NWORDS = word_count(NUM_PADS);
    localparam int PAD_W  = NWORDS * WORD_W;
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(STAT_BASE);

    logic [NUM_PADS-1:0] cur, prv, evt, clr, stat;

    pad_sync #(.NUM_PADS(NUM_PADS)) u_sync (
        .clk(clk), .rst(rst), .raw(pad_in), .cur(cur), .prv(prv)
    );

    trig_detect #(.NUM_PADS(NUM_PADS)) u_detect (
        .cur(cur), .prv(prv),
        .cfg_level(trig_level), .cfg_pos(trig_pos), .cfg_neg(trig_neg),
        .excluded(direct_en), .evt(evt)
    );

    stat_bank #(.NUM_PADS(NUM_PADS)) u_stat (
        .clk(clk), .rst(rst), .evt(evt), .clr(clr), .stat(stat)
    );

    // Address decode: word-aligned offset from the status base.
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-3:0] widx;
    logic              hit;

    assign off  = bus_addr - BASE;
    assign widx = off[ADDR_W-1:2];
    assign hit  = (bus_addr >= BASE) && (off[1:0] == 2'b00) && (int'(widx) < NWORDS);

    // Per-pad clear strobe from the addressed word.
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_clr
        localparam int WI = p / WORD_W;
        localparam int BI = p % WORD_W;
        assign clr[p] = bus_we && hit && (int'(widx) == WI) && bus_wdata[BI];
    end

    // Word view of the status vector, padded to whole words.
    logic [PAD_W-1:0]  stat_pad;
    logic [WORD_W-1:0] words [NWORDS];

    assign stat_pad = PAD_W'(stat);
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        assign words[w] = stat_pad[w*WORD_W +: WORD_W];
    end

    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NWORDS; w++)
            if (hit && (int'(widx) == w)) bus_rdata = words[w];
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |stat;
    end

    // R11: irq follows the OR of status one cycle later
    a_r11_irq_follows: assert property (@(posedge clk) disable iff (rst)
        irq == $past(|stat));

    // R10: no status bit rises for a pad excluded by direct mode
    a_r10_direct_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (((stat & ~$past(stat)) & $past(direct_en)) == '0));
endmodule

// File: tb/sim_gpio_irq_unit.sv
module sim_gpio_irq_unit;
    localparam int N = 40;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  pad_in, trig_level, trig_pos, trig_neg, direct_en;
    logic [11:0]   bus_addr;
    logic          bus_we;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    gpio_irq_unit #(.NUM_PADS(N)) u0 (
        .clk(clk), .rst(rst), .pad_in(pad_in), .trig_level(trig_level),
        .trig_pos(trig_pos), .trig_neg(trig_neg), .direct_en(direct_en),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        step(1);
        bus_we    = 1'b0;
    endtask

    task automatic cfg(input int p, input logic l, input logic ps, input logic ng);
        trig_level[p] = l;
        trig_pos[p]   = ps;
        trig_neg[p]   = ng;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(12'h800, d); check("R11 reset word0", d, 0);
        rd(12'h804, d); check("R11 reset word1", d, 0);
        check("R11 reset irq", 32'(irq), 0);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        cfg(3, 0, 1, 0);
        pad_in[3] = 1'b1;
        step(2); rd(12'h800, d); check("R12 not yet", d, 0);
        step(1); rd(12'h800, d); check("R1 R12 rise sets", d, 32'h8);
        check("R12 irq lags", 32'(irq), 0);
        step(1); check("R11 irq high", 32'(irq), 1);
        wr(12'h800, 32'h8);
        rd(12'h800, d); check("R8 cleared", d, 0);
        step(1); check("R11 irq low", 32'(irq), 0);
        pad_in[3] = 1'b0;
        step(4); rd(12'h800, d); check("R1 fall ignored", d, 0);
        cfg(3, 0, 0, 0);
    endtask

    task automatic t_fall();
        logic [31:0] d;
        cfg(5, 0, 0, 1);
        pad_in[5] = 1'b1;
        step(4); rd(12'h800, d); check("R2 rise ignored", d, 0);
        pad_in[5] = 1'b0;
        step(3); rd(12'h800, d); check("R2 fall sets", d, 32'h20);
        wr(12'h800, 32'hffff_ffff);
        cfg(5, 0, 0, 0);
    endtask

    task automatic t_both();
        logic [31:0] d;
        cfg(7, 0, 1, 1);
        pad_in[7] = 1'b1;
        step(3); rd(12'h800, d); check("R3 rise sets", d, 32'h80);
        wr(12'h800, 32'h80);
        pad_in[7] = 1'b0;
        step(3); rd(12'h800, d); check("R3 fall sets", d, 32'h80);
        wr(12'h800, 32'h80);
        rd(12'h800, d); check("R3 cleared", d, 0);
        cfg(7, 0, 0, 0);
    endtask

    task automatic t_level_hi();
        logic [31:0] d;
        cfg(34, 1, 1, 0);
        pad_in[34] = 1'b1;
        step(3);
        rd(12'h804, d); check("R4 R7 pad34 word1 bit2", d, 32'h4);
        rd(12'h800, d); check("R7 word0 clean", d, 0);
        wr(12'h804, 32'h4);
        rd(12'h804, d); check("R4 clear does not stick", d, 32'h4);
        rd(12'h808, d); check("R7 out of range zero", d, 0);
        rd(12'h7fc, d); check("R7 below base zero", d, 0);
        pad_in[34] = 1'b0;
        step(3);
        wr(12'h804, 32'h4);
        rd(12'h804, d); check("R4 clear after release", d, 0);
        cfg(34, 0, 0, 0);
    endtask

    task automatic t_level_lo();
        logic [31:0] d;
        cfg(9, 1, 0, 1);
        step(2); rd(12'h800, d); check("R5 low level sets", d, 32'h200);
        pad_in[9] = 1'b1;
        step(3);
        wr(12'h800, 32'h200);
        rd(12'h800, d); check("R5 high clears", d, 0);
        cfg(9, 0, 0, 0);
        pad_in[9] = 1'b0;
        step(4);
    endtask

    task automatic t_masked();
        logic [31:0] d;
        cfg(11, 0, 0, 0);
        cfg(12, 1, 0, 0);
        pad_in[11] = 1'b1; pad_in[12] = 1'b1;
        step(4);
        pad_in[11] = 1'b0; pad_in[12] = 1'b0;
        step(4);
        rd(12'h800, d); check("R6 masked no status", d, 0);
        check("R6 masked no irq", 32'(irq), 0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        cfg(3, 0, 1, 0); cfg(7, 0, 1, 0);
        pad_in[3] = 1'b1; pad_in[7] = 1'b1;
        step(3); rd(12'h800, d); check("R8 two set", d, 32'h88);
        wr(12'h800, 32'h8);
        rd(12'h800, d); check("R8 one cleared", d, 32'h80);
        wr(12'h800, 32'h0);
        rd(12'h800, d); check("R8 zero write keeps", d, 32'h80);
        wr(12'h800, 32'hffff_ffff);
        rd(12'h800, d); check("R8 all ones clears", d, 0);
        pad_in[3] = 1'b0; pad_in[7] = 1'b0;
        step(4);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        pad_in[3] = 1'b1;
        step(2);
        wr(12'h800, 32'h8);
        rd(12'h800, d); check("R9 event beats clear", d, 32'h8);
        wr(12'h800, 32'h8);
        rd(12'h800, d); check("R9 later clear works", d, 0);
        pad_in[3] = 1'b0;
        cfg(3, 0, 0, 0); cfg(7, 0, 0, 0);
        step(4);
    endtask

    task automatic t_direct();
        logic [31:0] d;
        cfg(13, 0, 1, 0);
        direct_en[13] = 1'b1;
        pad_in[13] = 1'b1;
        step(4);
        rd(12'h800, d); check("R10 direct excluded", d, 0);
        check("R10 direct no irq", 32'(irq), 0);
    endtask

    initial begin
        step(100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        pad_in = '0; trig_level = '0; trig_pos = '0; trig_neg = '0; direct_en = '0;
        bus_addr = 12'h800; bus_we = 1'b0; bus_wdata = '0;
        step(4);
        rst = 1'b0;
        step(1);
        t_reset();
        t_rise();
        t_fall();
        t_both();
        t_level_hi();
        t_level_lo();
        t_masked();
        t_w1c();
        t_collide();
        t_direct();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule